// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is an I2C bus master that software steers one bus primitive at a time through a byte-wide register port. A write to the command register with the GO bit set makes the engine perform one action: a start condition, a repeated start, one byte sent with the acknowledge bit sampled, one byte received followed by an acknowledge or a not-acknowledge, or a stop condition. When the action finishes, the engine reports a two-bit completion status in the command register and sets an interrupt flag. The flag reaches the `irq` output only while the interrupt enable is set.

The engine only pulls the bus lines low. `scl_drive_low` and `sda_drive_low` go to open-drain pads, and the resolved SDA level comes back on `sda_in`. Timing comes from a quarter-period divider. One SCL period is 64 × (clock-time + 1) module clocks, and it is split into four equal quarters. A local-reset bit in the control register holds the engine, the bus lines, the status and the interrupt flag cleared while it is set.

The sequencer has five states. `C_IDLE` waits for an accepted command. It branches to `C_START`, to `C_RESTART`, to `C_BYTE` or to `C_STOP`, or it completes at once for aborted and unknown commands. Each of `C_START`, `C_RESTART` and `C_STOP` runs four quarters and then returns to `C_IDLE`. `C_BYTE` runs nine bits of four quarters each and then returns to `C_IDLE`. It leaves early, to `C_IDLE` with the bus released, when a transmit bit is overdriven.

Register offsets: 0 control (bit 0 local reset), 1 clock-time, 2 command, 3 data, 8 interrupt clear / flag, 10 interrupt enable (bit 0).

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, SCL and SDA are both released, `irq` is low, and a read of the command register (offset 2) returns 0.
- R2: A write to offset 2 starts a command only when bit 7 (GO) is 1 and no command is running. A read of offset 2 returns {busy, status[1:0], 0, code[3:0]}, where busy is 1 from acceptance to completion. A command write made while busy leaves the latched code unchanged.
- R3: The SCL period during a byte is 64 × (clock-time + 1) module clocks, and each action is built from four equal quarters.
- R4: Code 1 on an idle bus, and codes 1 or 2 on an owned bus, pull SDA low while SCL is high. After that, SCL is held low and the completion status is 0.
- R5: Code 3 sends the data register MSB first, and SDA changes only while SCL is low. The ninth bit is released and sampled: low gives status 1 (ACK), high gives status 2 (NACK).
- R6: Codes 6 and 7 shift in eight bits MSB first into the data register (offset 3). On the ninth bit SDA is driven low for code 6 and released for code 7. The status is 0.
- R7: Code 10 on an owned bus releases SDA while SCL is high and leaves both lines released, with status 0.
- R8: Codes 2, 3, 6, 7 or 10 issued while the bus is not owned complete with status 3 and cause no bus activity.
- R9: During a transmitted data bit, if the engine releases SDA and samples it low, the command ends with status 3, both lines are released, and the bus is no longer owned.
- R10: Any other code with GO completes with status 0 and leaves the bus state unchanged.
- R11: Every completion sets the interrupt flag, and `irq` equals flag AND enable bit. Writing 1 to bit 0 of offset 8 clears the flag. A completion in the same cycle wins over the clear.
- R12: While control bit 0 is 1, busy, status and the flag stay 0, both lines stay released, and commands are ignored. Clock-time, data and enable keep their values. Once the bit is cleared, the bus is no longer owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| irq | output | 1 | Level interrupt: flag AND enable |
| scl_drive_low | output | 1 | Pull SCL low when 1 |
| sda_drive_low | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA bus level |

## Verification
The hardest case to reach is a transmit bit in which the engine releases SDA and another device holds the line low. That case is the only path into a mid-byte abort. The bench models a bus device that follows SCL edges and pulls SDA low on chosen bits. It reaches the abort by holding SDA low before a 0xFF transmit, so the first data bit is overdriven. The same device model returns data bytes and ACK or NACK. It also records the level on every SCL high phase and the SCL period, which lets the bench check bit order and timing at the pins.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CLKT = 4'd1;
    localparam logic [3:0] A_CMD  = 4'd2;
    localparam logic [3:0] A_DATA = 4'd3;
    localparam logic [3:0] A_ICLR = 4'd8;
    localparam logic [3:0] A_IEN  = 4'd10;

    localparam logic [3:0] OP_START     = 4'd1;
    localparam logic [3:0] OP_RESTART   = 4'd2;
    localparam logic [3:0] OP_SEND      = 4'd3;
    localparam logic [3:0] OP_RECV_ACK  = 4'd6;
    localparam logic [3:0] OP_RECV_NACK = 4'd7;
    localparam logic [3:0] OP_STOP      = 4'd10;

    localparam logic [1:0] CS_NORMAL = 2'd0;
    localparam logic [1:0] CS_ACK    = 2'd1;
    localparam logic [1:0] CS_NACK   = 2'd2;
    localparam logic [1:0] CS_ABORT  = 2'd3;

    typedef enum logic [2:0] {
        C_IDLE, C_START, C_RESTART, C_BYTE, C_STOP
    } cstate_e;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
    parameter int QDIV = 16,
    parameter int CT_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [CT_W-1:0] clk_time,
    output logic            tick
);
    localparam int CNT_W = $clog2((1 << CT_W) * QDIV);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = (CNT_W'(clk_time) + CNT_W'(1)) * CNT_W'(QDIV) - CNT_W'(1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (cnt == lim) cnt <= '0;
        else                 cnt <= cnt + CNT_W'(1);
    end

    // quarters are at least QDIV cycles long, so ticks never touch
    p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       srst,
    input  logic       go,
    input  logic [3:0] op,
    input  logic [7:0] tx_byte,
    input  logic       tick,
    input  logic       bus_sda,
    output logic       run,
    output logic       done,
    output logic [1:0] stat,
    output logic [7:0] rx_byte,
    output logic       scl_low,
    output logic       sda_low
);
    cstate_e    state;
    logic [1:0] phase;
    logic [3:0] bit_idx;
    logic [7:0] sh;
    logic       samp, held, is_tx, ack_low;

    assign run     = (state != C_IDLE);
    assign rx_byte = sh;

    // state register and sequencing
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || srst) begin
            state <= C_IDLE; phase <= '0; bit_idx <= '0; sh <= '0;
            samp <= 1'b0; held <= 1'b0; is_tx <= 1'b0; ack_low <= 1'b0;
            done <= 1'b0; stat <= CS_NORMAL;
        end else begin
            done <= 1'b0;
            unique case (state)
                C_IDLE: if (go) begin
                    phase   <= '0;
                    bit_idx <= '0;
                    case (op)
                        OP_START: state <= held ? C_RESTART : C_START;
                        OP_RESTART, OP_STOP:
                            if (held) state <= (op == OP_STOP) ? C_STOP : C_RESTART;
                            else begin done <= 1'b1; stat <= CS_ABORT; end
                        OP_SEND:
                            if (held) begin state <= C_BYTE; is_tx <= 1'b1; sh <= tx_byte; end
                            else begin done <= 1'b1; stat <= CS_ABORT; end
                        OP_RECV_ACK, OP_RECV_NACK:
                            if (held) begin
                                state <= C_BYTE; is_tx <= 1'b0; sh <= 8'hFF;
                                ack_low <= (op == OP_RECV_ACK);
                            end else begin done <= 1'b1; stat <= CS_ABORT; end
                        default: begin done <= 1'b1; stat <= CS_NORMAL; end
                    endcase
                end
                C_START, C_RESTART, C_STOP: if (tick) begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd3) begin
                        state <= C_IDLE;
                        done  <= 1'b1;
                        stat  <= CS_NORMAL;
                        held  <= (state != C_STOP);
                    end
                end
                C_BYTE: if (tick) begin
                    phase <= phase + 2'd1;
                    if (phase == 2'd2) begin
                        samp <= bus_sda;
                        if (is_tx && bit_idx != 4'd8 && sh[7] && !bus_sda) begin
                            state <= C_IDLE; held <= 1'b0;
                            done  <= 1'b1;   stat <= CS_ABORT;
                        end
                    end
                    if (phase == 2'd3) begin
                        if (bit_idx == 4'd8) begin
                            state <= C_IDLE;
                            done  <= 1'b1;
                            stat  <= is_tx ? (samp ? CS_NACK : CS_ACK) : CS_NORMAL;
                        end else begin
                            sh      <= {sh[6:0], samp};
                            bit_idx <= bit_idx + 4'd1;
                        end
                    end
                end
            endcase
        end
    end

    // line outputs (1 = pull low)
    always_comb begin
        scl_low = 1'b0;
        sda_low = 1'b0;
        unique case (state)
            C_IDLE:    scl_low = held;
            C_START:   begin scl_low = (phase == 2'd3); sda_low = (phase != 2'd0); end
            C_RESTART: begin scl_low = (phase == 2'd0) || (phase == 2'd3); sda_low = phase[1]; end
            C_BYTE: begin
                scl_low = (phase == 2'd0) || (phase == 2'd3);
                sda_low = (bit_idx == 4'd8) ? (!is_tx && ack_low) : (is_tx && !sh[7]);
            end
            C_STOP:    begin scl_low = (phase == 2'd0); sda_low = !phase[1]; end
        endcase
    end

    p_sda_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == C_BYTE && $past(state) == C_BYTE && sda_low != $past(sda_low))
        |-> (scl_low && $past(scl_low)));

    p_abort_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && stat == CS_ABORT) |-> (!scl_low && !sda_low));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2cm_pkg::*;
#(
    parameter int SCL_DIV = 64,
    parameter int CT_W    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [3:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic       scl_drive_low,
    output logic       sda_drive_low,
    input  logic       sda_in
);
    localparam int QDIV = SCL_DIV / 4;

    logic            ctrl_rst, busy, int_flag, int_en;
    logic [CT_W-1:0] clk_time;
    logic [3:0]      cmd_code;
    logic [1:0]      status;
    logic [7:0]      data_q;
    logic            accept, core_run, core_done, tick;
    logic [1:0]      core_stat;
    logic [7:0]      core_rx;

    assign accept = reg_wr && (reg_addr == A_CMD) && reg_wdata[7] && !busy && !ctrl_rst;
    assign irq    = int_flag && int_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_rst <= 1'b0; clk_time <= '0; cmd_code <= '0; busy <= 1'b0;
            status <= CS_NORMAL; data_q <= '0; int_flag <= 1'b0; int_en <= 1'b0;
        end else begin
            if (reg_wr && reg_addr == A_CTRL) ctrl_rst <= reg_wdata[0];
            if (reg_wr && reg_addr == A_CLKT) clk_time <= reg_wdata[CT_W-1:0];
            if (reg_wr && reg_addr == A_IEN)  int_en   <= reg_wdata[0];
            if (reg_wr && reg_addr == A_DATA) data_q   <= reg_wdata;
            if (ctrl_rst) begin
                busy <= 1'b0; status <= CS_NORMAL; int_flag <= 1'b0;
            end else begin
                if (accept) begin busy <= 1'b1; cmd_code <= reg_wdata[3:0]; end
                if (reg_wr && reg_addr == A_ICLR && reg_wdata[0]) int_flag <= 1'b0;
                if (core_done) begin
                    busy     <= 1'b0;
                    status   <= core_stat;
                    int_flag <= 1'b1;
                    if (core_stat == CS_NORMAL &&
                        (cmd_code == OP_RECV_ACK || cmd_code == OP_RECV_NACK))
                        data_q <= core_rx;
                end
            end
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_CTRL:  reg_rdata = {7'd0, ctrl_rst};
            A_CLKT:  reg_rdata = 8'(clk_time);
            A_CMD:   reg_rdata = {busy, status, 1'b0, cmd_code};
            A_DATA:  reg_rdata = data_q;
            A_ICLR:  reg_rdata = {7'd0, int_flag};
            A_IEN:   reg_rdata = {7'd0, int_en};
            default: reg_rdata = 8'd0;
        endcase
    end

    i2cm_qtick #(.QDIV(QDIV), .CT_W(CT_W)) u_qtick (
        .clk(clk), .rst_n(rst_n), .run(core_run), .clk_time(clk_time), .tick(tick)
    );

    i2cm_engine u_engine (
        .clk(clk), .rst_n(rst_n), .srst(ctrl_rst), .go(accept),
        .op(reg_wdata[3:0]), .tx_byte(data_q), .tick(tick), .bus_sda(sda_in),
        .run(core_run), .done(core_done), .stat(core_stat), .rx_byte(core_rx),
        .scl_low(scl_drive_low), .sda_low(sda_drive_low)
    );

    p_busy_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && reg_wr && reg_addr == A_CMD) |=> $stable(cmd_code));

    p_done_sets_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && !ctrl_rst) |=> int_flag);

    p_local_reset_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rst |=> (!busy && !int_flag && !scl_drive_low && !sda_drive_low));
endmodule

// File: tb/i2c_cmd_master_bench.sv
module i2c_cmd_master_bench;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, slave_low = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic       irq, scl_drive_low, sda_drive_low, scl_in, sda_in;
    int checks = 0, fails = 0, cyc = 0, fall_hi = 0, rise_hi = 0;
    logic prev_scl = 1'b1, prev_sda = 1'b1, finished = 1'b0;

    assign scl_in = !scl_drive_low;
    assign sda_in = !(sda_drive_low || slave_low);

    i2c_cmd_master u_i2c_cmd_master (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_drive_low(scl_drive_low), .sda_drive_low(sda_drive_low), .sda_in(sda_in)
    );

    always #(CLK_NS/2) clk = !clk;
    always @(posedge clk) cyc <= cyc + 1;

    // SDA edges while SCL stays high (start / stop conditions)
    always @(negedge clk) begin
        if (prev_scl === 1'b1 && scl_in === 1'b1) begin
            if (prev_sda === 1'b1 && sda_in === 1'b0) fall_hi <= fall_hi + 1;
            if (prev_sda === 1'b0 && sda_in === 1'b1) rise_hi <= rise_hi + 1;
        end
        prev_scl <= scl_in;
        prev_sda <= sda_in;
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1; d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [7:0] v;
        for (int k = 0; k < 20000; k++) begin
            rd(4'd2, v);
            if (!v[7]) break;
        end
    endtask

    task automatic run_cmd(input logic [3:0] code, output logic [1:0] st);
        logic [7:0] v;
        wr(4'd2, {4'h8, code});
        wait_done();
        rd(4'd2, v);
        st = v[6:5];
    endtask

    task automatic slave_bits(input logic [8:0] lowpat, output logic [8:0] seen, output int period);
        int t0 = 0, t1 = 0;
        for (int i = 0; i < 9; i++) begin
            slave_low = lowpat[8-i];
            while (scl_in !== 1'b1) @(negedge clk);
            if (i == 0) t0 = cyc;
            if (i == 1) t1 = cyc;
            seen[8-i] = sda_in;
            while (scl_in !== 1'b0) @(negedge clk);
        end
        slave_low = 1'b0;
        period = t1 - t0;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(4'd2, v);
        chk("R1", "command read", v, 0);
        chk("R1", "scl released", scl_in, 1);
        chk("R1", "sda released", sda_in, 1);
        chk("R1", "irq", irq, 0);
    endtask

    task automatic t_nogo();
        logic [7:0] v;
        wr(4'd2, 8'h01);
        repeat (100) @(negedge clk);
        rd(4'd2, v);
        chk("R2", "no GO busy", v[7], 0);
        chk("R2", "no GO scl idle", scl_in, 1);
        chk("R2", "no GO irq", irq, 0);
    endtask

    task automatic t_idle_abort();
        logic [1:0] st;
        int r0 = fall_hi;
        run_cmd(4'd10, st);
        chk("R8", "stop on idle status", st, 3);
        chk("R8", "no bus activity", fall_hi - r0, 0);
        chk("R8", "scl released", scl_in, 1);
        chk("R11", "irq after completion", irq, 1);
        wr(4'd8, 8'h01);
        chk("R11", "irq after clear", irq, 0);
        run_cmd(4'd3, st);
        chk("R8", "send on idle status", st, 3);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_unknown();
        logic [1:0] st;
        logic held_before = scl_drive_low;
        run_cmd(4'd4, st);
        chk("R10", "unknown status", st, 0);
        chk("R10", "bus state kept", scl_drive_low, held_before);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_start();
        logic [7:0] v;
        int f0 = fall_hi;
        wr(4'd2, 8'h81);
        rd(4'd2, v);
        chk("R2", "busy while running", v[7], 1);
        wr(4'd2, 8'h8A);
        wait_done();
        rd(4'd2, v);
        chk("R2", "code kept after busy write", v[3:0], 1);
        chk("R4", "start status", v[6:5], 0);
        chk("R4", "sda fell with scl high", fall_hi - f0, 1);
        chk("R4", "scl held low", scl_in, 0);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_tx(input logic [7:0] b, input logic ack, input int exp_period);
        logic [8:0] seen;
        logic [7:0] v;
        int period, f0 = fall_hi, r0 = rise_hi;
        wr(4'd3, b);
        fork
            wr(4'd2, 8'h83);
            slave_bits({8'h00, ack}, seen, period);
        join
        wait_done();
        rd(4'd2, v);
        chk("R5", "bits sent MSB first", seen[8:1], b);
        chk("R5", "tx status", v[6:5], ack ? 1 : 2);
        chk("R5", "sda only moves with scl low", (fall_hi - f0) + (rise_hi - r0), 0);
        chk("R3", "scl period", period, exp_period);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_rx(input logic [7:0] b, input logic [3:0] code);
        logic [8:0] seen;
        logic [7:0] v;
        int period;
        fork
            wr(4'd2, {4'h8, code});
            slave_bits({~b, 1'b0}, seen, period);
        join
        wait_done();
        rd(4'd2, v);
        chk("R6", "rx status", v[6:5], 0);
        chk("R6", "ack bit level", seen[0], (code == 4'd6) ? 0 : 1);
        rd(4'd3, v);
        chk("R6", "received byte", v, b);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_restart();
        logic [1:0] st;
        int f0 = fall_hi;
        run_cmd(4'd2, st);
        chk("R4", "restart status", st, 0);
        chk("R4", "restart sda fell with scl high", fall_hi - f0, 1);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_stop();
        logic [1:0] st;
        int r0 = rise_hi;
        run_cmd(4'd10, st);
        chk("R7", "stop status", st, 0);
        chk("R7", "sda rose with scl high", rise_hi - r0, 1);
        chk("R7", "lines released", {scl_in, sda_in}, 3);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_abort_tx();
        logic [1:0] st;
        run_cmd(4'd1, st);
        wr(4'd3, 8'hFF);
        slave_low = 1'b1;
        run_cmd(4'd3, st);
        chk("R9", "overdriven bit status", st, 3);
        chk("R9", "scl released", scl_drive_low, 0);
        chk("R9", "sda released", sda_drive_low, 0);
        slave_low = 1'b0;
        run_cmd(4'd10, st);
        chk("R9", "bus not owned after abort", st, 3);
        wr(4'd8, 8'h01);
    endtask

    task automatic t_local_reset();
        logic [1:0] st;
        logic [7:0] v;
        run_cmd(4'd1, st);
        wr(4'd2, 8'h83);
        repeat (50) @(negedge clk);
        wr(4'd0, 8'h01);
        repeat (3) @(negedge clk);
        rd(4'd2, v);
        chk("R12", "busy cleared", v[7], 0);
        chk("R12", "lines released", {scl_in, sda_in}, 3);
        chk("R12", "flag cleared", irq, 0);
        wr(4'd2, 8'h81);
        rd(4'd2, v);
        chk("R12", "command ignored", v[7], 0);
        rd(4'd1, v);
        chk("R12", "clock-time kept", v, 1);
        wr(4'd0, 8'h00);
        run_cmd(4'd10, st);
        chk("R12", "bus idle after local reset", st, 3);
    endtask

    task automatic t_irq_enable();
        wr(4'd10, 8'h00);
        chk("R11", "irq masked", irq, 0);
        wr(4'd10, 8'h01);
        chk("R11", "irq unmasked pending flag", irq, 1);
        wr(4'd8, 8'h01);
        chk("R11", "irq cleared", irq, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        wr(4'd1, 8'h01);
        wr(4'd10, 8'h01);
        t_nogo();
        t_idle_abort();
        t_unknown();
        t_start();
        t_tx(8'hA6, 1'b1, 128);
        t_tx(8'h35, 1'b0, 128);
        wr(4'd1, 8'h00);
        t_rx(8'hA5, 4'd6);
        t_rx(8'h3C, 4'd7);
        t_tx(8'h81, 1'b1, 64);
        wr(4'd1, 8'h01);
        t_restart();
        t_stop();
        t_abort_tx();
        t_local_reset();
        t_irq_enable();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule